// File: doc/BRIEF.md
# Cache Line Zeroing Engine

This block clears one cache line of memory per request. A requester presents a byte address together with a variant flag. The engine rounds the address down to the start of its 128-byte line and then writes zero to the whole line. It does this with a sequence of 64-bit stores on a valid/ready write port. When the last store has been taken, the engine raises a one-cycle completion pulse.

The variant flag carries the choice between two opcode forms. Both forms produce identical write traffic, so the flag has no effect on the output.

Only one request is in flight at a time. While a line is being cleared, the request port reports not-ready, so a requester that keeps its valid high simply waits.

Top module: `czl_line_zero`

## Requirements
- R1: While rst_ni is low, and right after it is released, the engine is idle: req_ready_o=1, wr_valid_o=0 and done_o=0. A reset during a clear abandons the clear with no write left pending.
- R2: The first write after an accepted request targets the request address with bits [6:0] forced to zero (the line base).
- R3: Each accepted request produces exactly 16 accepted writes. After the 16th write, wr_valid_o is low.
- R4: Write k (k = 0..15) targets line base + 8*k, issued in ascending k order.
- R5: wr_data_o is zero on every write.
- R6: wr_be_o is 8'hFF on every write.
- R7: A request with req_variant_i=1 produces exactly the same writes, ready and done timing as one with req_variant_i=0.
- R8: req_ready_o is low from the cycle after acceptance until the 16th write is accepted. A request held valid during that time is not taken and does not alter the writes in progress.
- R9: done_o is high for exactly one cycle, the cycle after the 16th write is accepted, and at no other time. req_ready_o is high again in that same cycle.
- R10: While wr_valid_o=1 and wr_ready_i=0, wr_addr_o and wr_data_o keep their values into the next cycle, and wr_valid_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request will be taken |
| req_addr_i | input | 64 | Byte address inside the line to clear |
| req_variant_i | input | 1 | Opcode form selector, no behavioural effect |
| wr_valid_o | output | 1 | Write beat present |
| wr_ready_i | input | 1 | Memory takes the write beat |
| wr_addr_o | output | 64 | Byte address of the write beat |
| wr_data_o | output | 64 | Write data, always zero |
| wr_be_o | output | 8 | Byte enables, all set |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a memory that can stall for any number of cycles. They also assume that a requester's address matters only in the cycle in which valid and ready are both high. The base and step properties rely on this: they compare each write address with the request address or the previous write address seen one cycle earlier. The stimulus follows these rules. It applies a new request only while the engine is idle, and it holds req_valid_i high during some clears with a different address, which the engine must not take. It drives wr_ready_i with three stall patterns: always ready, ready two cycles in three, and ready one cycle in four. These run across a sweep of in-line offsets, both variant values and extreme addresses.

// File: rtl/czl_pkg.sv
package czl_pkg;
  typedef enum logic {
    CZL_IDLE = 1'b0,
    CZL_BUSY = 1'b1
  } czl_state_e;
endpackage

// File: rtl/czl_line_align.sv
module czl_line_align #(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  assign base_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/czl_beat_ctr.sv
module czl_beat_ctr #(
  parameter int BEATS  = 16,
  parameter int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] cnt_o,
  output logic              last_o
);
  localparam logic [BEAT_W-1:0] LastIdx = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] cnt_q;

  assign last_o = (cnt_q == LastIdx);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/czl_wr_gen.sv
module czl_wr_gen #(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int BEAT_W     = 4,
  parameter int WORD_SHIFT = 3
) (
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [BEAT_W-1:0]   beat_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [DATA_W/8-1:0] be_o
);
  logic [ADDR_W-1:0] off;

  // base has zero low bits, so OR acts as add
  assign off    = {{(ADDR_W-BEAT_W){1'b0}}, beat_i} << WORD_SHIFT;
  assign addr_o = base_i | off;
  assign data_o = '0;
  assign be_o   = '1;
endmodule

// File: rtl/czl_line_zero.sv
module czl_line_zero #(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                req_variant_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [DATA_W/8-1:0] wr_be_o,
  output logic                done_o
);
  import czl_pkg::*;

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BEATS      = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);

  czl_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic              done_q;
  logic [BEAT_W-1:0] beat;
  logic              beat_last;
  logic              accept_req;
  logic              wr_fire;
  logic              variant_unused;

  assign variant_unused = req_variant_i;  // both opcode forms behave the same

  assign req_ready_o = (state_q == CZL_IDLE);
  assign accept_req  = req_valid_i && req_ready_o;
  assign wr_valid_o  = (state_q == CZL_BUSY);
  assign wr_fire     = wr_valid_o && wr_ready_i;
  assign done_o      = done_q;

  czl_line_align #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) align_i (
    .addr_i (req_addr_i),
    .base_o (base_d)
  );

  czl_beat_ctr #(
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W)
  ) ctr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept_req),
    .step_i  (wr_fire),
    .cnt_o   (beat),
    .last_o  (beat_last)
  );

  czl_wr_gen #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BEAT_W     (BEAT_W),
    .WORD_SHIFT (WORD_SHIFT)
  ) gen_i (
    .base_i (base_q),
    .beat_i (beat),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o),
    .be_o   (wr_be_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CZL_IDLE;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= wr_fire && beat_last;
      if (accept_req) begin
        state_q <= CZL_BUSY;
        base_q  <= base_d;
      end else if (wr_fire && beat_last) begin
        state_q <= CZL_IDLE;
      end
    end
  end
endmodule

// File: rtl/czl_line_zero_chk.sv
module czl_line_zero_chk #(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 128
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic [ADDR_W-1:0]   req_addr_i,
  input logic                wr_valid_o,
  input logic                wr_ready_i,
  input logic [ADDR_W-1:0]   wr_addr_o,
  input logic [DATA_W-1:0]   wr_data_o,
  input logic [DATA_W/8-1:0] wr_be_o,
  input logic                done_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WS         = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] LineMask = ADDR_W'(LINE_BYTES - 1);

  logic wr_fire;
  logic wr_last;
  assign wr_fire = wr_valid_o && wr_ready_i;
  assign wr_last = (wr_addr_o[OFF_W-1:WS] == '1);

  assert_start_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> wr_valid_o && (wr_addr_o == ($past(req_addr_i) & ~LineMask)));

  assert_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && wr_last |=> !wr_valid_o && done_o);

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && !wr_last |=> wr_valid_o && (wr_addr_o == $past(wr_addr_o) + ADDR_W'(WORD_BYTES)));

  assert_zero_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_data_o == '0));

  assert_full_be_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (&wr_be_o));

  assert_busy_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !req_ready_o);

  assert_done_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_fire && wr_last));

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
endmodule

bind czl_line_zero czl_line_zero_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LINE_BYTES (LINE_BYTES)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .wr_be_o     (wr_be_o),
  .done_o      (done_o)
);

// File: tb/czl_line_zero_tb.sv
`timescale 1ns/1ps
module czl_line_zero_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_addr_i = '0;
  logic        req_variant_i = 1'b0;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b0;
  logic [63:0] wr_addr_o;
  logic [63:0] wr_data_o;
  logic [7:0]  wr_be_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  czl_line_zero dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_addr_i    (req_addr_i),
    .req_variant_i (req_variant_i),
    .wr_valid_o    (wr_valid_o),
    .wr_ready_i    (wr_ready_i),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o),
    .wr_be_o       (wr_be_o),
    .done_o        (done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit rdy_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 0;
      default: return (c % 4) == 0;
    endcase
  endfunction

  // one full clear; hold_req keeps a second request valid while busy
  task automatic run_req(input logic [63:0] addr, input bit variant, input int mode, input bit hold_req);
    logic [63:0] base;
    int beats;
    int guard;
    string t4;
    base = addr & ~64'h7F;
    t4 = variant ? "R7 R4" : "R4";
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8 idle ready", {63'd0, req_ready_o}, 64'd1);
    req_valid_i   = 1'b1;
    req_addr_i    = addr;
    req_variant_i = variant;
    wr_ready_i    = 1'b0;
    @(negedge clk_i);
    if (hold_req) begin
      req_addr_i    = ~addr;
      req_variant_i = ~variant;
    end else begin
      req_valid_i = 1'b0;
    end
    beats = 0;
    guard = 0;
    while (beats < 16 && guard < 400) begin
      wr_ready_i = rdy_pat(mode, guard);
      chk(wr_valid_o == 1'b1, "R3 valid during clear", {63'd0, wr_valid_o}, 64'd1);
      chk(wr_addr_o == base + 64'(8 * beats), beats == 0 ? "R2 base" : t4, wr_addr_o, base + 64'(8 * beats));
      chk(wr_data_o == 64'd0, "R5 zero data", wr_data_o, 64'd0);
      chk(wr_be_o == 8'hFF, "R6 byte enables", {56'd0, wr_be_o}, 64'hFF);
      chk(req_ready_o == 1'b0, "R8 ready low while busy", {63'd0, req_ready_o}, 64'd0);
      chk(done_o == 1'b0, "R9 no early done", {63'd0, done_o}, 64'd0);
      @(posedge clk_i);
      if (wr_ready_i) beats++;
      guard++;
      @(negedge clk_i);
      // stalled beat must still show the same address (R10)
      if (!wr_ready_i && beats < 16)
        chk(wr_addr_o == base + 64'(8 * beats) && wr_valid_o, "R10 stall hold", wr_addr_o, base + 64'(8 * beats));
    end
    req_valid_i = 1'b0;
    wr_ready_i  = 1'b1;
    chk(done_o == 1'b1, variant ? "R7 R9 done pulse" : "R9 done pulse", {63'd0, done_o}, 64'd1);
    chk(wr_valid_o == 1'b0, "R3 no extra write", {63'd0, wr_valid_o}, 64'd0);
    chk(req_ready_o == 1'b1, "R9 ready with done", {63'd0, req_ready_o}, 64'd1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 single cycle", {63'd0, done_o}, 64'd0);
    chk(wr_valid_o == 1'b0, "R3 stays idle", {63'd0, wr_valid_o}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1 && !wr_valid_o && !done_o, "R1 in reset",
        {61'd0, req_ready_o, wr_valid_o, done_o}, 64'd4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1 && !wr_valid_o && !done_o, "R1 after reset",
        {61'd0, req_ready_o, wr_valid_o, done_o}, 64'd4);

    for (int off = 0; off < 128; off += 9)
      for (int v = 0; v < 2; v++)
        for (int m = 0; m < 3; m++)
          run_req(64'h0000_1234_5678_9A00 + 64'(off) + 64'(m * 128), v[0], m, (off % 2) == 1);

    run_req(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1, 1'b1);
    run_req(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2, 1'b0);
    run_req(64'h0, 1'b0, 2, 1'b1);
    run_req(64'h8000_0000_0000_007F, 1'b1, 0, 1'b0);

    // reset in the middle of a clear (R1)
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = 64'h4000;
    wr_ready_i  = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!wr_valid_o && req_ready_o && !done_o, "R1 reset mid clear",
        {61'd0, req_ready_o, wr_valid_o, done_o}, 64'd4);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!wr_valid_o && !done_o, "R1 nothing pending", {62'd0, wr_valid_o, done_o}, 64'd0);
    run_req(64'h4010, 1'b0, 1, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule